// File: doc/BRIEF.md
# Run-Length Decoder with Look-Back Indexing

This block watches a non-return-to-zero data stream coming from a channel encoder. It samples the stream once per channel clock and measures how many clock periods each run lasts. A run is one stretch of constant level. Every run is classed as a mark (write) run or a space (erase) run. When a run ends, the block forms a 6-bit strategy index from the run that just ended and the run before it. A downstream write-strategy table uses that index to pick its pulse pattern. This look-back lets the table apply data-dependent pre-compensation.

A run that reaches sixteen clock periods is not a legal code run. The decoder leaves write operation, reports index 0 once and sits in a read state until the next level change. Two mode inputs control the block:
- Level-sensitive mode (`level_mode` high) takes the run type from the data level. Edge-only mode (`level_mode` low) simply alternates the type.
- A forced-erase control holds the decoder in read.

A second copy of the index and strobe comes out after a fixed latency, so the block's total input-to-output delay is always the same.

Top module: `rld_decoder`

## Requirements
- R1: The level sampled at the edge just after `data_in` is driven is the run's first sample. A run of L consecutive equal samples (1 ≤ L ≤ 15) that ends in a level change is reported by a one-cycle `strat_vld` pulse. The pulse comes one clock edge after the edge that samples the new level. `strat_idx` holds its value between pulses and is 0 after reset.
- R2: When a run reaches its 16th equal sample, `strat_vld` pulses with `strat_idx` = 0 on the following edge, and the decoder enters read. Later samples of that same long run produce no further pulse.
- R3: In edge-only mode (`level_mode` = 0), the first run after read is an erase run whatever its level, and the type then alternates at every level change.
- R4: In level-sensitive mode (`level_mode` = 1), a run sampled high is a write run and a run sampled low is an erase run.
- R5: The index of an erase run of length n depends on n and, for n = 3 to 5, on the previous run:
  - n = 1 or 2 gives index n.
  - n = 3 gives 3, 4 or 5 after a write run of length 3, 4 or 5, and 6 otherwise.
  - n = 4 gives 7, 8 or 9 after a write run of length 3, 4 or 5, and 10 otherwise.
  - n = 5 gives 11 after a length-3 write run, 12 after a length-4 write run, and 13 otherwise.
  - n = 6 to 15 gives n + 8, regardless of the previous run.
- R6: The index of a write run of length n depends on n and, for n = 1 to 5, on the previous run:
  - For n = 1 to 5 the index is 18 + 6n + (p − 1) when the previous run was an erase run of length p with 1 ≤ p ≤ 5.
  - For n = 1 to 5 the index is 18 + 6n + 5 for any other previous run.
  - n = 6 to 15 gives n + 48, regardless of the previous run.
- R7: The first run after read (whether read was entered after reset, after a long run or after forced erase) is treated as having an "other" previous run.
- R8: While `force_erase` is high, no strobe is produced, the decoder is in read and `rd_wr` is high. After release, the next level change starts a fresh run.
- R9: `rd_wr` is 0 while runs are being measured and decoded, and 1 in read.
- R10: `dly_idx`/`dly_vld` repeat `strat_idx`/`strat_vld` exactly LATENCY − 1 edges later. A level change sampled at edge n therefore shows up on the delayed outputs at edge n + LATENCY (28 by default).
- R11: After reset, `strat_vld` = 0, `strat_idx` = 0, `rd_wr` = 1, `dly_vld` = 0 and `dly_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | 1 | NRZ run-length data bit |
| level_mode | input | 1 | 1: run type from data level; 0: type toggles on each change |
| force_erase | input | 1 | Forced-erase mode; holds the decoder in read |
| strat_idx | output | 6 | Strategy index of the last reported run |
| strat_vld | output | 1 | One-cycle strobe for a new index |
| rd_wr | output | 1 | 1 in read or forced erase, 0 while decoding runs |
| dly_idx | output | 6 | Strategy index after the fixed latency |
| dly_vld | output | 1 | Strobe after the fixed latency |

## Verification
The bench builds the decoder with its default LATENCY of 28. This puts a 27-stage delay line in the path, so every delayed output can be compared against the directly observed index of 27 edges earlier. Directed runs walk every erase and write length from 1 to 15, with every preceding length that changes the index. They also cross the 15/16 boundary into read and back. Random runs mix both sensitivity modes, overlong runs and forced-erase windows.

// File: rtl/rld_pkg.sv
package rld_pkg;

  localparam int LEN_W = 4;
  localparam int IDX_W = 6;
  localparam logic [LEN_W-1:0] RUN_MAX = 4'd15;

  typedef logic [LEN_W-1:0] run_len_t;
  typedef logic [IDX_W-1:0] strat_idx_t;

  typedef enum logic {
    RUN_ERASE = 1'b0,
    RUN_WRITE = 1'b1
  } run_kind_t;

  // Description of a completed run kept for the look-back.
  typedef struct packed {
    logic      known;
    run_kind_t kind;
    run_len_t  len;
  } run_desc_t;

endpackage

// File: rtl/rld_sampler.sv
module rld_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic edge_det,
  output logic new_level
);

  logic smp_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      smp_q  <= data_in;
      last_q <= smp_q;
    end
  end

  assign edge_det  = smp_q ^ last_q;
  assign new_level = smp_q;

endmodule

// File: rtl/rld_index_map.sv
module rld_index_map
  import rld_pkg::*;
(
  input  run_kind_t  kind,
  input  run_len_t   len,
  input  run_desc_t  prev,
  output strat_idx_t idx
);

  logic       after_mid_write;
  logic       after_short_erase;
  strat_idx_t wr_base;

  always_comb begin
    after_mid_write   = prev.known && (prev.kind == RUN_WRITE) &&
                        (prev.len >= 4'd3) && (prev.len <= 4'd5);
    after_short_erase = prev.known && (prev.kind == RUN_ERASE) &&
                        (prev.len >= 4'd1) && (prev.len <= 4'd5);
    wr_base = strat_idx_t'(18) + strat_idx_t'(6) * strat_idx_t'(len);
    idx = '0;
    if (kind == RUN_ERASE) begin
      case (len)
        4'd0: idx = '0;
        4'd1, 4'd2: idx = strat_idx_t'(len);
        4'd3: idx = after_mid_write ? strat_idx_t'(prev.len) : strat_idx_t'(6);
        4'd4: idx = after_mid_write ? strat_idx_t'(4) + strat_idx_t'(prev.len)
                                    : strat_idx_t'(10);
        4'd5: begin
          if (after_mid_write && prev.len == 4'd3)      idx = strat_idx_t'(11);
          else if (after_mid_write && prev.len == 4'd4) idx = strat_idx_t'(12);
          else                                          idx = strat_idx_t'(13);
        end
        default: idx = strat_idx_t'(8) + strat_idx_t'(len);
      endcase
    end else begin
      if (len == 4'd0) begin
        idx = '0;
      end else if (len <= 4'd5) begin
        idx = after_short_erase ? wr_base + strat_idx_t'(prev.len) - strat_idx_t'(1)
                                : wr_base + strat_idx_t'(5);
      end else begin
        idx = strat_idx_t'(48) + strat_idx_t'(len);
      end
    end
  end

endmodule

// File: rtl/rld_run_tracker.sv
module rld_run_tracker
  import rld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_det,
  input  logic       new_level,
  input  logic       level_mode,
  input  logic       force_erase,
  input  strat_idx_t map_idx,
  output run_kind_t  kind_q,
  output run_len_t   len_q,
  output run_desc_t  prev_q,
  output logic       active_q,
  output strat_idx_t idx_q,
  output logic       vld_q
);

  run_kind_t  kind_d;
  run_len_t   len_d;
  run_desc_t  prev_d;
  logic       active_d;
  strat_idx_t idx_d;
  logic       vld_d;
  logic       run_en;
  logic       idx_en;

  always_comb begin
    kind_d   = kind_q;
    len_d    = len_q;
    prev_d   = prev_q;
    active_d = active_q;
    idx_d    = idx_q;
    vld_d    = 1'b0;
    run_en   = 1'b0;
    idx_en   = 1'b0;
    if (force_erase) begin
      active_d = 1'b0;
    end else if (active_q) begin
      run_en = 1'b1;
      if (edge_det) begin
        idx_en = 1'b1;
        vld_d  = 1'b1;
        idx_d  = map_idx;
        prev_d = '{known: 1'b1, kind: kind_q, len: len_q};
        len_d  = run_len_t'(1);
        if (level_mode) kind_d = new_level ? RUN_WRITE : RUN_ERASE;
        else            kind_d = (kind_q == RUN_WRITE) ? RUN_ERASE : RUN_WRITE;
      end else if (len_q == RUN_MAX) begin
        idx_en   = 1'b1;
        vld_d    = 1'b1;
        idx_d    = '0;
        active_d = 1'b0;
      end else begin
        len_d = len_q + run_len_t'(1);
      end
    end else if (edge_det) begin
      run_en   = 1'b1;
      active_d = 1'b1;
      len_d    = run_len_t'(1);
      prev_d   = '0;
      if (level_mode) kind_d = new_level ? RUN_WRITE : RUN_ERASE;
      else            kind_d = RUN_ERASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RUN_ERASE;
      len_q  <= '0;
      prev_q <= '0;
    end else if (run_en) begin
      kind_q <= kind_d;
      len_q  <= len_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (len_q >= 4'd1) && (len_q <= RUN_MAX)); // R1

  AST_OVERFLOW_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !edge_det && !force_erase && len_q == RUN_MAX)
      |=> (!active_q && vld_q && idx_q == '0)); // R2

  AST_EDGE_MODE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && edge_det && !level_mode && !force_erase)
      |=> (kind_q != $past(kind_q))); // R3

  AST_LEVEL_MODE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && level_mode && !force_erase)
      |=> (kind_q == ($past(new_level) ? RUN_WRITE : RUN_ERASE))); // R4

  AST_FRESH_LOOKBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && edge_det && !force_erase) |=> !prev_q.known); // R7

  AST_FORCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    force_erase |=> (!active_q && !vld_q)); // R8

endmodule

// File: rtl/rld_delay_line.sv
module rld_delay_line #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= '0;
        else        pipe_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= '0;
        else        pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/rld_decoder.sv
module rld_decoder
  import rld_pkg::*;
#(
  parameter int LATENCY = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_in,
  input  logic             level_mode,
  input  logic             force_erase,
  output logic [IDX_W-1:0] strat_idx,
  output logic             strat_vld,
  output logic             rd_wr,
  output logic [IDX_W-1:0] dly_idx,
  output logic             dly_vld
);

  localparam int DLY_STAGES = LATENCY - 1;
  localparam int DLY_W      = IDX_W + 1;

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       edge_det;
  logic       new_level;
  run_kind_t  kind_q;
  run_len_t   len_q;
  run_desc_t  prev_q;
  logic       active_q;
  strat_idx_t map_idx;
  strat_idx_t idx_q;
  logic       vld_q;
  logic [DLY_W-1:0] dly_out;

  rld_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .data_in   (data_in),
    .edge_det  (edge_det),
    .new_level (new_level)
  );

  rld_index_map u_map (
    .kind (kind_q),
    .len  (len_q),
    .prev (prev_q),
    .idx  (map_idx)
  );

  rld_run_tracker u_tracker (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .edge_det    (edge_det),
    .new_level   (new_level),
    .level_mode  (level_mode),
    .force_erase (force_erase),
    .map_idx     (map_idx),
    .kind_q      (kind_q),
    .len_q       (len_q),
    .prev_q      (prev_q),
    .active_q    (active_q),
    .idx_q       (idx_q),
    .vld_q       (vld_q)
  );

  rld_delay_line #(
    .WIDTH  (DLY_W),
    .STAGES (DLY_STAGES)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .din   ({vld_q, idx_q}),
    .dout  (dly_out)
  );

  assign strat_idx = idx_q;
  assign strat_vld = vld_q;
  assign rd_wr     = ~active_q;
  assign dly_vld   = dly_out[DLY_W-1];
  assign dly_idx   = dly_out[IDX_W-1:0];

  AST_RUN_STROBE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (strat_vld && strat_idx != '0) |-> !rd_wr); // R9

  AST_READ_MARK_IN_READ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (strat_vld && strat_idx == '0) |-> rd_wr); // R2

endmodule

// File: tb/tb_rld_decoder.sv
module tb_rld_decoder;

  localparam int LATENCY = 28;
  localparam int HIST    = 40000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       data_in = 1'b0;
  logic       level_mode = 1'b0;
  logic       force_erase = 1'b0;
  logic [5:0] strat_idx;
  logic       strat_vld;
  logic       rd_wr;
  logic [5:0] dly_idx;
  logic       dly_vld;

  always #5 clk = ~clk;

  rld_decoder #(.LATENCY(LATENCY)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_in     (data_in),
    .level_mode  (level_mode),
    .force_erase (force_erase),
    .strat_idx   (strat_idx),
    .strat_vld   (strat_vld),
    .rd_wr       (rd_wr),
    .dly_idx     (dly_idx),
    .dly_vld     (dly_vld)
  );

  int    checks = 0;
  int    fails = 0;
  int    k = 0;
  bit    done = 0;
  string tag = "R1";
  bit    sp1 = 0, sp2 = 0;
  bit    m_active = 0, m_w = 0, m_vld = 0;
  int    m_len = 0, m_idx = 0;
  bit    p_known = 0, p_w = 0;
  int    p_len = 0;
  int    h_idx [HIST];
  bit    h_vld [HIST];

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (step %0d)", req, what, act, exp, k);
    end
  endtask

  function automatic int ref_index(bit w, int len, bit pk, bit pw, int pl);
    bit mid_w = pk && pw && pl >= 3 && pl <= 5;
    if (!w) begin
      if (len >= 6) return len + 8;
      if (len <= 2) return len;
      if (len == 3) return mid_w ? pl : 6;
      if (len == 4) return mid_w ? pl + 4 : 10;
      if (mid_w && pl == 3) return 11;
      if (mid_w && pl == 4) return 12;
      return 13;
    end
    if (len >= 6) return len + 48;
    return 18 + 6 * len + ((pk && !pw && pl >= 1 && pl <= 5) ? pl - 1 : 5);
  endfunction

  task automatic step(bit d);
    string itag;
    data_in = d;
    m_vld = 0;
    if (force_erase) begin
      m_active = 0;
    end else if (m_active) begin
      if (sp1 != sp2) begin
        m_vld = 1;
        m_idx = ref_index(m_w, m_len, p_known, p_w, p_len);
        p_known = 1; p_w = m_w; p_len = m_len;
        m_len = 1;
        m_w = level_mode ? sp1 : !m_w;
      end else if (m_len == 15) begin
        m_active = 0; m_vld = 1; m_idx = 0;
      end else begin
        m_len++;
      end
    end else if (sp1 != sp2) begin
      m_active = 1; m_len = 1; p_known = 0;
      m_w = level_mode ? sp1 : 1'b0;
    end
    sp2 = sp1;
    sp1 = d;
    if (k < HIST) begin
      h_idx[k] = m_idx;
      h_vld[k] = m_vld;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(strat_vld), int'(m_vld), "strobe");
    itag = (m_idx == 0) ? "R2" : (m_idx < 24) ? "R5" : "R6";
    if (m_vld) chk(itag, int'(strat_idx), m_idx, "index");
    chk("R9", int'(rd_wr), int'(!m_active), "rd_wr");
    if (k >= LATENCY - 1 && k < HIST + LATENCY - 1) begin
      chk("R10", int'(dly_vld), int'(h_vld[k-(LATENCY-1)]), "delayed strobe");
      if (h_vld[k-(LATENCY-1)])
        chk("R10", int'(dly_idx), h_idx[k-(LATENCY-1)], "delayed index");
    end else if (k < LATENCY - 1) begin
      chk("R10", int'(dly_vld), 0, "delayed strobe");
    end
    k++;
  endtask

  task automatic run(bit lv, int len);
    for (int i = 0; i < len; i++) step(lv);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual 0 expected 1 (run did not finish)");
      summary();
      $finish;
    end
  end

  initial begin
    bit lv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", int'(strat_vld), 0, "reset strobe");
    chk("R11", int'(strat_idx), 0, "reset index");
    chk("R11", int'(rd_wr), 1, "reset rd_wr");
    chk("R11", int'(dly_vld), 0, "reset delayed strobe");
    chk("R11", int'(dly_idx), 0, "reset delayed index");

    // R4 / R6: level mode, every write length after every short erase
    level_mode = 1'b1;
    tag = "R4";
    for (int wl = 1; wl <= 5; wl++)
      for (int el = 1; el <= 6; el++) begin
        run(0, (el == 6) ? 7 : el);
        run(1, wl);
      end
    // R5: erase 3..5 after each write length
    for (int el = 3; el <= 5; el++)
      for (int wl = 1; wl <= 6; wl++) begin
        run(1, (wl == 6) ? 8 : wl);
        run(0, el);
      end
    // R5 / R6: every length in both types
    for (int len = 1; len <= 15; len++) begin
      run(1, len);
      run(0, len);
    end

    // R2: boundary 15 / 16 and long runs
    tag = "R2";
    run(1, 15);
    run(0, 16);
    run(1, 20);
    run(0, 2);
    run(1, 3);

    // R7: first run after read has an "other" previous run
    tag = "R7";
    run(0, 18);
    run(1, 4);
    run(0, 3);
    run(1, 2);

    // R3: edge-only mode, first run after read is erase even when high
    level_mode = 1'b0;
    tag = "R3";
    run(0, 20);
    run(1, 4);
    run(0, 3);
    run(1, 5);
    run(0, 1);
    run(1, 2);

    // R8: forced erase in the middle of runs
    tag = "R8";
    run(0, 3);
    force_erase = 1'b1;
    run(1, 4);
    run(0, 2);
    force_erase = 1'b0;
    run(1, 6);
    run(0, 3);
    run(1, 2);

    // Random runs (R1)
    tag = "R1";
    lv = 0;
    for (int n = 0; n < 400; n++) begin
      int r;
      int len;
      if (($urandom % 25) == 0) level_mode = ~level_mode;
      force_erase = (($urandom % 50) == 0);
      r = $urandom_range(1, 100);
      len = (r <= 8) ? $urandom_range(16, 19) : $urandom_range(1, 15);
      lv = ~lv;
      run(lv, len);
    end
    force_erase = 1'b0;
    run(~lv, 20);
    run(lv, LATENCY + 2);

    done = 1;
    summary();
    $finish;
  end

endmodule